// File: doc/BRIEF.md
# Light-Load Burst Mode Controller

This block chooses how a resonant converter's switching stage runs at light load. It takes three comparator flags that say whether the feedback level lies above a high-frequency entry threshold, a low-frequency entry threshold and a packet-stop threshold. It also takes a strobe that marks the end of each switching packet and a flag that reports a sudden drop in load. From these it selects one of three modes: continuous switching, high-frequency pulse skipping, or low-frequency burst. It drives a packet enable for the gate logic and a select that tells the energy loop which level sets packet energy. In burst mode that level is the fixed low-frequency entry level. In every other mode it is the live feedback level.

In burst mode the output is delivered in segments of several packets. The block times the interval between segment starts with a cycle counter. It raises or lowers the number of packets per segment so that segments repeat at a rate between 200 Hz and 400 Hz. A load-drop indication stops the active segment at once, so the output does not overshoot. Mode decisions are taken only at packet boundaries, so a packet is cut short only by a load drop.

Top module: `burst_mode_ctrl`

## Requirements
- R1: A synchronous active-low reset sets mode to normal (code 0), holds `pkt_en` low and holds `energy_fixed` low.
- R2: At a boundary with the high-frequency flag set, the mode becomes normal (code 0) and `pkt_en` goes high and stays high.
- R3: At a boundary with the high-frequency flag clear and the low-frequency flag set, outside burst, the mode becomes pulse skip (code 1). The enable for the next packet equals the packet-stop flag, and `energy_fixed` is 0.
- R4: At a boundary with both entry flags clear, outside burst, the mode becomes burst (code 2) with `pkt_en` low and `energy_fixed` 1. While idle in burst, a set low-frequency flag starts a segment.
- R5: A burst segment ends at a packet boundary only when the packets delivered have reached the target and the packet-stop flag is clear. While that flag stays set, packets continue.
- R6: At each segment start after the first one in a burst stay, the target rises by one if the start-to-start interval is under CLK_HZ/400 cycles. It falls by one if the interval is over CLK_HZ/200 cycles. The target stays within CNT_MIN..CNT_MAX, and the first segment of a stay uses CNT_DEF.
- R7: `load_drop` during an active burst segment clears `pkt_en` on the next edge, and the mode stays burst. In any other situation `load_drop` has no effect.
- R8: Mode and enable change only at a packet boundary, which is a `pkt_done` strobe or any cycle with `pkt_en` low.
- R9: Leaving burst (high-frequency flag set at a boundary, giving normal mode) restores the target to CNT_DEF.
- R10: Each comparator flag passes through a two-stage synchronizer, so a flag change first affects the outputs on the third rising edge after it is applied. `pkt_done` and `load_drop` act on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fb_gt_hf | input | 1 | Feedback above high-frequency entry threshold |
| fb_gt_lf | input | 1 | Feedback above low-frequency entry threshold |
| fb_gt_stop | input | 1 | Feedback above packet-stop threshold |
| pkt_done | input | 1 | One-cycle strobe at the end of each packet |
| load_drop | input | 1 | Sudden load-drop indication |
| mode | output | 2 | 0 normal, 1 pulse skip, 2 burst |
| pkt_en | output | 1 | Packet enable for the gate logic |
| energy_fixed | output | 1 | 1: packet energy uses the fixed burst-entry level |

## Verification
A comparator flag applied at a falling edge reaches the mode and enable registers on the third rising edge after it. The bench therefore holds each flag for at least three edges before it produces a boundary. It checks the exact latency once, by confirming that the mode is unchanged after two edges and changed after the third. `pkt_done` and `load_drop` act on the following rising edge, so each is driven for one cycle from a falling edge, and the result is read at the next falling edge. Segment lengths and targets are compared against a model in the bench. That model rebuilds the rate rule from cycle counts that the bench measures itself between the enable rises it sees.

// File: rtl/burst_pkg.sv
package burst_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_SKIP   = 2'd1,
    MODE_BURST  = 2'd2
  } mode_e;

  // Next packet target from the measured start-to-start interval.
  function automatic int unsigned next_target(
    input int unsigned cur,
    input int unsigned interval,
    input int unsigned fast_lim,
    input int unsigned slow_lim,
    input int unsigned lo,
    input int unsigned hi
  );
    if (interval < fast_lim && cur < hi) return cur + 1;
    if (interval > slow_lim && cur > lo) return cur - 1;
    return cur;
  endfunction

endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/seg_rate_adapt.sv
module seg_rate_adapt
  import burst_pkg::*;
#(
  parameter int CLK_HZ  = 100000,
  parameter int CNT_MIN = 2,
  parameter int CNT_MAX = 6,
  parameter int CNT_DEF = 4,
  parameter int CW      = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_burst,
  input  logic          seg_start,
  input  logic          restore,
  output logic [CW-1:0] target
);

  localparam int FAST_CYC = CLK_HZ / 400;
  localparam int SLOW_CYC = CLK_HZ / 200;
  localparam int PW       = $clog2(SLOW_CYC + 2);

  logic [PW-1:0] per_q;
  logic          have_prev_q;
  logic [CW-1:0] target_q;

  always_ff @(posedge clk) begin
    if (!rst_n || restore) begin
      per_q       <= '0;
      have_prev_q <= 1'b0;
      target_q    <= CW'(CNT_DEF);
    end else if (seg_start) begin
      per_q       <= PW'(1);
      have_prev_q <= 1'b1;
      if (have_prev_q)
        target_q <= CW'(next_target(32'(target_q), 32'(per_q), FAST_CYC,
                                    SLOW_CYC, CNT_MIN, CNT_MAX));
    end else if (in_burst && per_q <= PW'(SLOW_CYC)) begin
      per_q <= per_q + PW'(1);
    end
  end

  assign target = target_q;

  assert_target_clamp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (target_q >= CW'(CNT_MIN)) && (target_q <= CW'(CNT_MAX)));

  assert_restore_default_R9: assert property (@(posedge clk) disable iff (!rst_n)
    restore |=> (target_q == CW'(CNT_DEF)));

endmodule

// File: rtl/burst_mode_ctrl.sv
module burst_mode_ctrl
  import burst_pkg::*;
#(
  parameter int CLK_HZ      = 100000,
  parameter int CNT_MIN     = 2,
  parameter int CNT_MAX     = 6,
  parameter int CNT_DEF     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fb_gt_hf,
  input  logic       fb_gt_lf,
  input  logic       fb_gt_stop,
  input  logic       pkt_done,
  input  logic       load_drop,
  output logic [1:0] mode,
  output logic       pkt_en,
  output logic       energy_fixed
);

  localparam int CW = $clog2(CNT_MAX + 1);

  logic [2:0]    flags_s;
  logic          hf_s, lf_s, stop_s;
  mode_e         mode_q, mode_d;
  logic          en_q, en_d;
  logic [CW-1:0] cnt_q, cnt_d, cnt_inc;
  logic [CW-1:0] target;
  logic          alive_q;

  // Named internal events
  logic bnd_w, drop_cut_w, seg_start_w, seg_end_w, leave_burst_w;

  flag_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({fb_gt_hf, fb_gt_lf, fb_gt_stop}),
    .q    (flags_s)
  );
  assign {hf_s, lf_s, stop_s} = flags_s;

  seg_rate_adapt #(
    .CLK_HZ(CLK_HZ), .CNT_MIN(CNT_MIN), .CNT_MAX(CNT_MAX),
    .CNT_DEF(CNT_DEF), .CW(CW)
  ) u_rate (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_burst (mode_q == MODE_BURST),
    .seg_start(seg_start_w),
    .restore  (leave_burst_w),
    .target   (target)
  );

  assign bnd_w      = pkt_done | ~en_q;
  assign drop_cut_w = (mode_q == MODE_BURST) & en_q & load_drop;
  assign cnt_inc    = (cnt_q == CW'(CNT_MAX)) ? cnt_q : cnt_q + CW'(1);

  always_comb begin
    mode_d        = mode_q;
    en_d          = en_q;
    cnt_d         = cnt_q;
    seg_start_w   = 1'b0;
    seg_end_w     = 1'b0;
    leave_burst_w = 1'b0;
    if (drop_cut_w) begin
      en_d      = 1'b0;
      cnt_d     = '0;
      seg_end_w = 1'b1;
    end else if (bnd_w) begin
      unique case (mode_q)
        MODE_BURST: begin
          if (hf_s) begin
            mode_d        = MODE_NORMAL;
            en_d          = 1'b1;
            cnt_d         = '0;
            leave_burst_w = 1'b1;
          end else if (en_q) begin
            cnt_d = cnt_inc;
            if (cnt_inc >= target && !stop_s) begin
              en_d      = 1'b0;
              cnt_d     = '0;
              seg_end_w = 1'b1;
            end
          end else if (lf_s) begin
            en_d        = 1'b1;
            cnt_d       = '0;
            seg_start_w = 1'b1;
          end
        end
        default: begin
          cnt_d = '0;
          if (hf_s) begin
            mode_d = MODE_NORMAL;
            en_d   = 1'b1;
          end else if (lf_s) begin
            mode_d = MODE_SKIP;
            en_d   = stop_s;
          end else begin
            mode_d = MODE_BURST;
            en_d   = 1'b0;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= MODE_NORMAL;
      en_q    <= 1'b0;
      cnt_q   <= '0;
      alive_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      en_q    <= en_d;
      cnt_q   <= cnt_d;
      alive_q <= 1'b1;
    end
  end

  assign mode         = mode_q;
  assign pkt_en       = en_q;
  assign energy_fixed = (mode_q == MODE_BURST);

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (mode_q == MODE_NORMAL && !en_q));

  assert_seg_end_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (alive_q && mode_q == MODE_BURST && $past(mode_q) == MODE_BURST && $fell(en_q))
      |-> $past(load_drop | ~stop_s));

  assert_drop_cut_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_BURST && en_q && load_drop) |=> (!en_q && mode_q == MODE_BURST));

  assert_hold_between_bnd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !pkt_done && !drop_cut_w) |=> ($stable(mode_q) && en_q));

endmodule

// File: tb/burst_mode_ctrl_tb.sv
module burst_mode_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ  = 100000;
  localparam int CNT_MIN = 2;
  localparam int CNT_MAX = 6;
  localparam int CNT_DEF = 4;
  localparam int FAST_LIM = CLK_HZ / 400;
  localparam int SLOW_LIM = CLK_HZ / 200;

  logic clk = 1'b0;
  logic rst_n, fb_gt_hf, fb_gt_lf, fb_gt_stop, pkt_done, load_drop;
  logic [1:0] mode;
  logic pkt_en, energy_fixed;

  burst_mode_ctrl #(.CLK_HZ(CLK_HZ), .CNT_MIN(CNT_MIN), .CNT_MAX(CNT_MAX),
                    .CNT_DEF(CNT_DEF), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .fb_gt_hf(fb_gt_hf), .fb_gt_lf(fb_gt_lf),
    .fb_gt_stop(fb_gt_stop), .pkt_done(pkt_done), .load_drop(load_drop),
    .mode(mode), .pkt_en(pkt_en), .energy_fixed(energy_fixed)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // Bench model of the rate rule
  int mdl_tgt = CNT_DEF;
  bit mdl_valid = 0;
  int mdl_last = 0;

  // {hf, lf, stop, mode[1:0], en, sel}
  localparam logic [6:0] VEC [7] = '{
    7'b111_00_1_0, 7'b011_01_1_0, 7'b010_01_0_0, 7'b011_01_1_0,
    7'b111_00_1_0, 7'b000_10_0_1, 7'b111_00_1_0 };
  localparam int GAPS [10] = '{0, 20, 20, 20, 600, 600, 600, 600, 600, 300};

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [1:0] m);
    if (m == 2'd0) return "R2";
    if (m == 2'd1) return "R3";
    return "R4";
  endfunction

  task automatic pulse_done();
    pkt_done = 1'b1;
    @(negedge clk);
    pkt_done = 1'b0;
  endtask

  task automatic start_seg(input bit hold_stop);
    int waited = 0;
    fb_gt_lf = 1'b1;
    fb_gt_stop = hold_stop;
    while (!pkt_en && waited < 20) begin
      @(negedge clk);
      waited++;
    end
    fb_gt_lf = 1'b0;
    if (!pkt_en) chk(0, "R4", "segment start", 0, 1);
    if (mdl_valid) begin
      int span = cyc - mdl_last;
      if (span < FAST_LIM) begin
        if (mdl_tgt < CNT_MAX) mdl_tgt = mdl_tgt + 1;
      end else if (span > SLOW_LIM) begin
        if (mdl_tgt > CNT_MIN) mdl_tgt = mdl_tgt - 1;
      end
    end
    mdl_valid = 1;
    mdl_last = cyc;
  endtask

  task automatic run_seg(input int pregap, input int hold, output int npk);
    repeat (pregap) @(negedge clk);
    start_seg(hold > 0);
    npk = 0;
    for (int k = 0; k < 40; k++) begin
      repeat (3) @(negedge clk);
      pulse_done();
      npk++;
      if (hold > 0 && npk == mdl_tgt + hold) begin
        fb_gt_stop = 1'b0;
        repeat (3) @(negedge clk);
      end
      if (!pkt_en) break;
    end
  endtask

  task automatic enter_burst();
    fb_gt_hf = 1'b0; fb_gt_lf = 1'b0; fb_gt_stop = 1'b0;
    repeat (4) @(negedge clk);
    if (pkt_en) pulse_done();
    @(negedge clk);
    mdl_tgt = CNT_DEF;
    mdl_valid = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog run incomplete actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int n;
    rst_n = 1'b0; fb_gt_hf = 1'b1; fb_gt_lf = 1'b1; fb_gt_stop = 1'b1;
    pkt_done = 1'b0; load_drop = 1'b0;
    repeat (3) @(negedge clk);
    chk(mode == 2'd0, "R1", "reset mode", mode, 0);
    chk(pkt_en == 1'b0, "R1", "reset enable", pkt_en, 0);
    chk(energy_fixed == 1'b0, "R1", "reset select", energy_fixed, 0);
    rst_n = 1'b1;

    // Classification table
    foreach (VEC[i]) begin
      {fb_gt_hf, fb_gt_lf, fb_gt_stop} = VEC[i][6:4];
      repeat (4) @(negedge clk);
      if (pkt_en) pulse_done();
      repeat (2) @(negedge clk);
      chk(mode == VEC[i][3:2], tag_of(VEC[i][3:2]), "table mode", mode, VEC[i][3:2]);
      chk(pkt_en == VEC[i][1], tag_of(VEC[i][3:2]), "table enable", pkt_en, VEC[i][1]);
      chk(energy_fixed == VEC[i][0], tag_of(VEC[i][3:2]), "table select",
          energy_fixed, VEC[i][0]);
    end

    // R7: load drop ignored in normal mode
    load_drop = 1'b1;
    @(negedge clk);
    load_drop = 1'b0;
    @(negedge clk);
    chk(pkt_en == 1'b1 && mode == 2'd0, "R7", "drop ignored in normal", pkt_en, 1);

    // R8: no mode change without a boundary
    fb_gt_hf = 1'b0; fb_gt_lf = 1'b1; fb_gt_stop = 1'b1;
    repeat (10) @(negedge clk);
    chk(mode == 2'd0, "R8", "mode held without boundary", mode, 0);
    pulse_done();
    chk(mode == 2'd1, "R8", "mode changes at boundary", mode, 1);

    // Burst and rate adaptation
    enter_burst();
    chk(mode == 2'd2 && energy_fixed, "R4", "burst entry", mode, 2);
    foreach (GAPS[i]) begin
      run_seg(GAPS[i], 0, n);
      chk(n == mdl_tgt, "R6", "packets per segment", n, mdl_tgt);
      chk(!pkt_en && mode == 2'd2, "R5", "segment closed", pkt_en, 0);
    end
    chk(mdl_tgt != CNT_DEF, "R6", "target moved away from default", mdl_tgt, CNT_MIN);

    // R5: packet-stop flag holds the segment open
    run_seg(300, 2, n);
    chk(n == mdl_tgt + 3, "R5", "stop flag extends segment", n, mdl_tgt + 3);

    // R7: load drop ends segment at once
    repeat (300) @(negedge clk);
    start_seg(1'b0);
    repeat (3) @(negedge clk);
    pulse_done();
    chk(pkt_en == 1'b1, "R7", "segment still running", pkt_en, 1);
    load_drop = 1'b1;
    @(negedge clk);
    load_drop = 1'b0;
    chk(pkt_en == 1'b0, "R7", "drop cuts segment", pkt_en, 0);
    chk(mode == 2'd2, "R7", "mode stays burst after drop", mode, 2);
    repeat (5) @(negedge clk);
    chk(pkt_en == 1'b0, "R7", "segment stays closed", pkt_en, 0);

    // R10: flag latency on exit; R9 on re-entry
    fb_gt_hf = 1'b1; fb_gt_lf = 1'b1; fb_gt_stop = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(mode == 2'd2, "R10", "no change after two edges", mode, 2);
    @(negedge clk);
    chk(mode == 2'd0 && pkt_en, "R10", "change on third edge", mode, 0);
    repeat (3) @(negedge clk);
    enter_burst();
    run_seg(0, 0, n);
    chk(n == CNT_DEF, "R9", "default count after re-entry", n, CNT_DEF);

    // R1: reset mid-operation
    rst_n = 1'b0;
    @(negedge clk);
    chk(mode == 2'd0 && !pkt_en && !energy_fixed, "R1", "reset in burst", mode, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule